// File: doc/BRIEF.md
# Four-Channel Programmable Down-Counter/Timer

The block has four independent 8-bit down-counting channels. A host programs them through a byte-wide register port, which has a chip enable, a two-bit channel select, read and write strobes and an 8-bit data bus. Each channel runs in one of two modes. In timer mode it counts system clocks through a prescaler. In counter mode it counts the selected edges on its own trigger input. When a channel reaches zero it reloads its time constant, pulses a zero-count output (channels 0 to 2 only) and can post an interrupt.

A channel is set up with a control byte followed by a time-constant byte. The host writes one vector base, and the block forms a separate vector for each channel from it. Pending interrupts are prioritised by channel number and are chained to neighbouring blocks through an enable-in / enable-out pair. The host retires the highest-priority request with a clear strobe.

Top module: `ctc_quad`

## Requirements
- R1: After reset, every channel is stopped with a count of 0, no zero-count pulse is output, `int_o` is low and `ieo_o` equals `iei_i`.
- R2: A write with data bit 0 = 1 to a channel that is not awaiting a constant is a control byte. Its fields are: bit 7 interrupt enable, bit 6 counter mode (0 = timer), bit 5 prescale 256 (0 = 16), bit 4 rising edge (0 = falling), bit 3 timer waits for trigger, bit 2 constant follows, bit 1 stop.
- R3: After a control byte with bit 2 set, the next write to that channel loads the time constant and the count, and arms the channel. A constant of 0 gives a period of 256 counts.
- R4: In timer mode the count decrements once every 16 or 256 clocks, as bit 5 selects. Counting starts the clock after arming.
- R5: In counter mode the count decrements on each selected edge of `trg_i[n]`.
- R6: A timer armed with bit 3 set holds its count until the selected trigger edge, then starts counting.
- R7: When the count is 1 and a decrement falls due, the count reloads the constant, and `zc_o[n]` (n = 0..2) pulses high for exactly one clock.
- R8: While `ce_i` and `rd_i` are high, `rdata_o` shows the live count of the channel on `sel_i`; otherwise it is 0.
- R9: A write with bit 0 = 0 on channel 0 stores bits 7:3 as the vector base. On channels 1 to 3 such a write is ignored. `vec_o` = {base, channel number in bits 2:1, 0}.
- R10: A reload with interrupts enabled sets that channel's pending flag. `int_o` = `iei_i` and any pending. `ieo_o` = `iei_i` and none pending. The lowest-numbered pending channel wins.
- R11: `clr_i` clears only the highest-priority pending flag. A control byte with bit 7 = 0 clears that channel's pending flag.
- R12: A control byte with bit 1 set halts the channel, and its count then stays unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ce_i | input | 1 | Chip enable for register access |
| sel_i | input | 2 | Channel select |
| wr_i | input | 1 | Write strobe |
| rd_i | input | 1 | Read strobe |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Count readback |
| trg_i | input | 4 | Per-channel clock/trigger inputs |
| zc_o | output | 3 | Zero-count pulses, channels 0 to 2 |
| iei_i | input | 1 | Daisy-chain enable in |
| clr_i | input | 1 | Clears the highest-priority pending interrupt |
| int_o | output | 1 | Interrupt request |
| ieo_o | output | 1 | Daisy-chain enable out |
| vec_o | output | 8 | Vector of the winning channel |

## Verification
The hardest state to reach is a time constant of 0 in counter mode. Confirming the 256-count period needs a channel stopped, re-armed and then fed exactly 256 selected edges while other channels keep raising and clearing interrupts. The stimulus re-arms channel 1 with a stop-plus-reload control byte and counts the driven rising edges from the constant write onward. It checks that the next zero-count pulse lands after edge 256, while a cycle-accurate behavioural model tracks all four channels, the priority chain and the readback on every clock.

// File: rtl/ctc_quad_pkg.sv
package ctc_quad_pkg;
  typedef struct packed {
    logic ie;
    logic cnt_mode;
    logic ps_big;
    logic rise;
    logic trg_start;
  } chan_cfg_t;

  localparam int CB_CTRL = 0;
  localparam int CB_STOP = 1;
  localparam int CB_TCF  = 2;
  localparam int CB_TRG  = 3;
  localparam int CB_EDGE = 4;
  localparam int CB_PS   = 5;
  localparam int CB_MODE = 6;
  localparam int CB_IE   = 7;
endpackage

// File: rtl/ctc_quad_chan.sv
module ctc_quad_chan
  import ctc_quad_pkg::*;
#(
  parameter int W      = 8,
  parameter int PS_LO  = 16,
  parameter int PS_HI  = 256,
  parameter bit HAS_ZC = 1'b1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         wr_i,
  input  logic [W-1:0] wdata_i,
  input  logic         trg_i,
  input  logic         clr_i,
  output logic [W-1:0] cnt_o,
  output logic         zc_o,
  output logic         pend_o,
  output logic         wait_tc_o
);
  localparam int PSW = $clog2(PS_HI);

  chan_cfg_t      cfg_q;
  logic [W-1:0]   tc_q, cnt_q;
  logic [PSW-1:0] ps_q;
  logic           run_q, wtc_q, wtrg_q, trg_q, pend_q;
  logic           edge_hit, ps_wrap, tick, zero, tc_wr, ctrl_wr;

  assign edge_hit = cfg_q.rise ? (trg_i & ~trg_q) : (~trg_i & trg_q);
  assign ps_wrap  = ps_q == (cfg_q.ps_big ? PSW'(PS_HI - 1) : PSW'(PS_LO - 1));
  assign tick     = run_q & (cfg_q.cnt_mode ? edge_hit : ps_wrap);
  assign zero     = tick & (cnt_q == W'(1));
  assign tc_wr    = wr_i & wtc_q;
  assign ctrl_wr  = wr_i & ~wtc_q & wdata_i[CB_CTRL];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q  <= '0;
      tc_q   <= '0;
      cnt_q  <= '0;
      ps_q   <= '0;
      run_q  <= 1'b0;
      wtc_q  <= 1'b0;
      wtrg_q <= 1'b0;
      trg_q  <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      trg_q <= trg_i;
      if (run_q && !cfg_q.cnt_mode) ps_q <= ps_wrap ? '0 : ps_q + 1'b1;
      if (tick) cnt_q <= zero ? tc_q : cnt_q - 1'b1;
      if (wtrg_q && edge_hit) begin
        run_q  <= 1'b1;
        wtrg_q <= 1'b0;
        ps_q   <= '0;
      end
      if (zero && cfg_q.ie) pend_q <= 1'b1;
      else if (clr_i)       pend_q <= 1'b0;
      // later assignments override the counting path
      if (tc_wr) begin
        tc_q  <= wdata_i;
        cnt_q <= wdata_i;
        ps_q  <= '0;
        wtc_q <= 1'b0;
        if (!cfg_q.cnt_mode && cfg_q.trg_start) begin
          wtrg_q <= 1'b1;
          run_q  <= 1'b0;
        end else begin
          wtrg_q <= 1'b0;
          run_q  <= 1'b1;
        end
      end else if (ctrl_wr) begin
        cfg_q <= '{ie:        wdata_i[CB_IE],
                   cnt_mode:  wdata_i[CB_MODE],
                   ps_big:    wdata_i[CB_PS],
                   rise:      wdata_i[CB_EDGE],
                   trg_start: wdata_i[CB_TRG]};
        if (wdata_i[CB_STOP]) begin
          run_q  <= 1'b0;
          wtrg_q <= 1'b0;
        end
        if (wdata_i[CB_TCF]) wtc_q <= 1'b1;
        if (!wdata_i[CB_IE]) pend_q <= 1'b0;
      end
    end
  end

  generate
    if (HAS_ZC) begin : g_zc
      logic zc_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) zc_q <= 1'b0;
        else         zc_q <= zero;
      end
      assign zc_o = zc_q;

      AST_ZC_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        zc_q |=> !zc_q); // R7
    end else begin : g_nozc
      assign zc_o = 1'b0;
    end
  endgenerate

  assign cnt_o     = cnt_q;
  assign pend_o    = pend_q;
  assign wait_tc_o = wtc_q;

  AST_RELOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    zero |=> cnt_q == tc_q); // R7
  AST_STOP_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_q && !wr_i) |=> $stable(cnt_q)); // R12
  AST_TC_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && wtc_q) |=> cnt_q == $past(wdata_i)); // R3
  AST_PEND_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_q && !clr_i && !wr_i) |=> pend_q); // R11
endmodule

// File: rtl/ctc_quad_prio.sv
module ctc_quad_prio #(
  parameter int NCH = 4,
  parameter int IW  = $clog2(NCH)
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic [NCH-1:0] pend_i,
  input  logic           iei_i,
  output logic [NCH-1:0] grant_o,
  output logic [IW-1:0]  idx_o,
  output logic           int_o,
  output logic           ieo_o
);
  logic any;

  always_comb begin
    idx_o = '0;
    for (int i = NCH - 1; i >= 0; i--) begin
      if (pend_i[i]) idx_o = IW'(i);
    end
  end

  assign any     = |pend_i;
  assign grant_o = any ? (NCH'(1) << idx_o) : '0;
  assign int_o   = iei_i & any;
  assign ieo_o   = iei_i & ~any;

  AST_VEC_PENDING: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int_o |-> pend_i[idx_o]); // R10
endmodule

// File: rtl/ctc_quad.sv
module ctc_quad
  import ctc_quad_pkg::*;
#(
  parameter int NCH   = 4,
  parameter int NZC   = 3,
  parameter int W     = 8,
  parameter int PS_LO = 16,
  parameter int PS_HI = 256,
  parameter int SW    = $clog2(NCH)
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           ce_i,
  input  logic [SW-1:0]  sel_i,
  input  logic           wr_i,
  input  logic           rd_i,
  input  logic [W-1:0]   wdata_i,
  output logic [W-1:0]   rdata_o,
  input  logic [NCH-1:0] trg_i,
  output logic [NZC-1:0] zc_o,
  input  logic           iei_i,
  input  logic           clr_i,
  output logic           int_o,
  output logic           ieo_o,
  output logic [W-1:0]   vec_o
);
  localparam int VBW = W - SW - 1;

  logic [W-1:0]   cnt [NCH];
  logic [NCH-1:0] zc_all, pend, grant, wtc;
  logic [SW-1:0]  idx;
  logic [VBW-1:0] base_q;
  logic           unused_zc;

  generate
    for (genvar i = 0; i < NCH; i++) begin : g_ch
      ctc_quad_chan #(
        .W(W), .PS_LO(PS_LO), .PS_HI(PS_HI), .HAS_ZC(i < NZC)
      ) u_chan (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .wr_i     (ce_i & wr_i & (sel_i == SW'(i))),
        .wdata_i  (wdata_i),
        .trg_i    (trg_i[i]),
        .clr_i    (clr_i & grant[i]),
        .cnt_o    (cnt[i]),
        .zc_o     (zc_all[i]),
        .pend_o   (pend[i]),
        .wait_tc_o(wtc[i])
      );
    end
  endgenerate

  assign zc_o      = zc_all[NZC-1:0];
  assign unused_zc = |zc_all[NCH-1:NZC];

  ctc_quad_prio #(.NCH(NCH), .IW(SW)) u_prio (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .pend_i (pend),
    .iei_i  (iei_i),
    .grant_o(grant),
    .idx_o  (idx),
    .int_o  (int_o),
    .ieo_o  (ieo_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) base_q <= '0;
    else if (ce_i && wr_i && sel_i == '0 && !wdata_i[CB_CTRL] && !wtc[0])
      base_q <= wdata_i[W-1:SW+1];
  end

  assign vec_o   = {base_q, idx, 1'b0};
  assign rdata_o = (ce_i && rd_i) ? cnt[sel_i] : '0;

  AST_BASE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ce_i && wr_i && sel_i != '0) |=> $stable(base_q)); // R9
endmodule

// File: tb/ctc_quad_tb.sv
module ctc_quad_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ce = 1'b0, wr = 1'b0, rd = 1'b0, iei = 1'b1, clr = 1'b0;
  logic [1:0] sel = '0;
  logic [7:0] wdata = '0;
  logic [3:0] trg = 4'b1000;
  logic [7:0] rdata, vec;
  logic [2:0] zc;
  logic       intr, ieo;

  int checks = 0, failures = 0, cyc = 0;

  always #2 clk = ~clk;

  ctc_quad u_dut (
    .clk_i(clk), .rst_ni(rst_n), .ce_i(ce), .sel_i(sel), .wr_i(wr), .rd_i(rd),
    .wdata_i(wdata), .rdata_o(rdata), .trg_i(trg), .zc_o(zc), .iei_i(iei),
    .clr_i(clr), .int_o(intr), .ieo_o(ieo), .vec_o(vec)
  );

  // behavioural reference model
  int m_cnt[4], m_tc[4], m_ps[4], m_base;
  bit m_run[4], m_wtc[4], m_wtrg[4], m_ie[4], m_mode[4], m_big[4], m_rise[4];
  bit m_tst[4], m_pend[4], m_zc[4], m_trgq[4];

  always @(posedge clk) begin
    if (!rst_n) begin
      m_base = 0;
      for (int c = 0; c < 4; c++) begin
        m_cnt[c] = 0; m_tc[c] = 0; m_ps[c] = 0; m_run[c] = 0; m_wtc[c] = 0;
        m_wtrg[c] = 0; m_ie[c] = 0; m_mode[c] = 0; m_big[c] = 0; m_rise[c] = 0;
        m_tst[c] = 0; m_pend[c] = 0; m_zc[c] = 0; m_trgq[c] = 0;
      end
    end else begin
      int hp;
      bit hav;
      hp = 0; hav = 0;
      for (int c = 3; c >= 0; c--) if (m_pend[c]) begin hp = c; hav = 1; end
      for (int c = 0; c < 4; c++) begin
        bit e, tk, z;
        int lim;
        lim = m_big[c] ? 255 : 15;
        e = m_rise[c] ? (trg[c] && !m_trgq[c]) : (!trg[c] && m_trgq[c]);
        tk = m_run[c] && (m_mode[c] ? e : (m_ps[c] == lim));
        z = tk && (m_cnt[c] == 1);
        if (m_run[c] && !m_mode[c]) m_ps[c] = (m_ps[c] == lim) ? 0 : m_ps[c] + 1;
        if (tk) m_cnt[c] = z ? m_tc[c] : ((m_cnt[c] + 255) % 256);
        if (m_wtrg[c] && e) begin m_run[c] = 1; m_wtrg[c] = 0; m_ps[c] = 0; end
        if (z && m_ie[c]) m_pend[c] = 1;
        else if (clr && hav && hp == c) m_pend[c] = 0;
        if (ce && wr && sel == c) begin
          if (m_wtc[c]) begin
            m_tc[c] = wdata; m_cnt[c] = wdata; m_ps[c] = 0; m_wtc[c] = 0;
            if (!m_mode[c] && m_tst[c]) begin m_wtrg[c] = 1; m_run[c] = 0; end
            else begin m_wtrg[c] = 0; m_run[c] = 1; end
          end else if (wdata[0]) begin
            m_ie[c] = wdata[7]; m_mode[c] = wdata[6]; m_big[c] = wdata[5];
            m_rise[c] = wdata[4]; m_tst[c] = wdata[3];
            if (wdata[1]) begin m_run[c] = 0; m_wtrg[c] = 0; end
            if (wdata[2]) m_wtc[c] = 1;
            if (!wdata[7]) m_pend[c] = 0;
          end else if (c == 0) begin
            m_base = wdata >> 3;
          end
        end
        m_zc[c] = z;
        m_trgq[c] = trg[c];
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s cycle=%0d actual=%0h expected=%0h", tag, cyc, act, exp);
    end
  endtask

  int last_zc[3] = '{0, 0, 0};
  int period[3] = '{0, 0, 0};
  int edges_run = 0, edges1 = 0;

  // one clock, outputs compared against the model away from the edge
  task automatic step();
    int hp, ex_rd, ex_vec;
    bit hav;
    @(negedge clk);
    #1;
    cyc++;
    hp = 0; hav = 0;
    for (int c = 3; c >= 0; c--) if (m_pend[c]) begin hp = c; hav = 1; end
    ex_rd  = (ce && rd) ? m_cnt[sel] : 0;
    ex_vec = (m_base << 3) | (hp << 1);
    chk(rdata == ex_rd, "R8 R3 R4 R5 readback", rdata, ex_rd);
    chk(zc == {m_zc[2], m_zc[1], m_zc[0]}, "R7 zero pulse", zc, {m_zc[2], m_zc[1], m_zc[0]});
    chk(intr == (iei && hav), "R10 R11 int", intr, iei && hav);
    chk(ieo == (iei && !hav), "R10 ieo", ieo, iei && !hav);
    chk(vec == ex_vec, "R9 vector", vec, ex_vec);
    for (int c = 0; c < 3; c++) if (zc[c]) begin
      period[c] = cyc - last_zc[c];
      last_zc[c] = cyc;
    end
    if (zc[1]) begin edges1 = edges_run; edges_run = 0; end
  endtask

  task automatic wr_reg(input int ch, input int d);
    ce = 1; wr = 1; sel = ch[1:0]; wdata = d[7:0];
    step();
    wr = 0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      ce = 1; rd = 1; sel = i[1:0];
      clr = (i % 40 == 39);
      if (i % 3 == 0) begin
        trg[1] = ~trg[1];
        if (trg[1]) edges_run++;
      end
      step();
      clr = 0;
    end
  endtask

  bit seen_int;
  int held;

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    step();
    // R1: reset state
    chk(zc == 3'b000, "R1 zc after reset", zc, 0);
    chk(intr == 1'b0, "R1 int after reset", intr, 0);
    chk(ieo == 1'b1, "R1 ieo after reset", ieo, 1);
    ce = 1; rd = 1;
    for (int c = 0; c < 4; c++) begin
      sel = c[1:0];
      step();
      chk(rdata == 8'd0, "R1 count after reset", rdata, 0);
    end

    wr_reg(0, 8'hA8);   // R9 base 0x15
    wr_reg(1, 8'h50);   // R9 ignored on channel 1
    wr_reg(0, 8'h85); wr_reg(0, 3);   // R2 timer /16 ie
    wr_reg(1, 8'hD5); wr_reg(1, 2);   // R5 counter rising ie
    wr_reg(2, 8'h25); wr_reg(2, 1);   // R4 timer /256
    wr_reg(3, 8'h8D); wr_reg(3, 2);   // R6 trigger start, falling
    edges_run = 0;

    for (int i = 0; i < 20; i++) begin
      ce = 1; rd = 1; sel = 2'd3;
      step();
    end
    chk(rdata == 8'd2, "R6 waits for trigger", rdata, 2);
    trg[3] = 1'b0;

    seen_int = 0;
    for (int i = 0; i < 70; i++) begin
      idle(10);
      if (intr && !seen_int) begin
        seen_int = 1;
        chk(vec[7:3] == 5'h15, "R9 base kept", vec[7:3], 5'h15);
      end
      if (i == 30) iei = 0;
      if (i == 32) iei = 1;
    end
    chk(seen_int, "R10 interrupt seen", seen_int, 1);
    chk(period[0] == 48, "R4 timer /16 period", period[0], 48);
    chk(period[2] == 256, "R2 R4 timer /256 period", period[2], 256);
    chk(edges1 == 2, "R5 edges per reload", edges1, 2);

    // R12 stop channel 0
    wr_reg(0, 8'h03);
    ce = 1; rd = 1; sel = 0;
    step();
    held = rdata;
    idle(40);
    ce = 1; rd = 1; sel = 0;
    step();
    chk(rdata == held, "R12 count held after stop", rdata, held);

    // R3 constant 0 means 256 edges
    wr_reg(1, 8'hD7); wr_reg(1, 0);
    edges_run = 0;
    idle(1600);
    chk(edges1 == 256, "R3 constant zero period", edges1, 256);

    // R11 disabling interrupts drops pending flags
    wr_reg(1, 8'h43); wr_reg(3, 8'h03); wr_reg(2, 8'h03);
    step();
    chk(intr == 1'b0, "R11 pending cleared by control", intr, 0);

    // R10 chain closed upstream
    wr_reg(0, 8'h85); wr_reg(0, 1);
    idle(40);
    iei = 0;
    step();
    chk(intr == 1'b0 && ieo == 1'b0, "R10 chain blocked", {intr, ieo}, 0);
    iei = 1;
    step();

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule